// File: doc/BRIEF.md
# I2S Target-Mode Stereo Receiver

This block listens to a two-channel serial audio bus driven by an external controller and turns it into parallel sample pairs inside the system clock domain. The bit clock, word select and serial data pins are brought in through synchronizer chains. The bit clock is then edge-detected on the system clock, and every rising bit-clock edge delivers one data bit and one word-select sample to the receiver.

Words are framed only by word-select transitions. When the word-select level sampled on a rising bit-clock edge differs from the level sampled on the previous rising edge, the bit taken on that edge is the final (least significant) bit of the word that is ending. That word is then stored and the assembly register starts empty for the next word. Words arrive most significant bit first in two's complement. The transmitter's word length is never negotiated: bits beyond the output width are dropped, and missing low-order bits read as zero. A left word followed by a right word is presented together on two parallel outputs, with a single-cycle strobe.

Top module: `i2s_tgt_rx`

## Requirements
- R1: While reset is asserted, and right after it is released, o_valid is 0 and o_left and o_right are all zeros.
- R2: Data is sampled only on rising edges of i_sck. A word whose length equals DATA_W is reproduced exactly, with its first received bit at output bit DATA_W-1.
- R3: On the rising i_sck edge where the sampled i_ws differs from the value sampled on the previous rising edge, the i_sd bit taken belongs to the word that is ending, as its last bit. The next bit starts a new word.
- R4: A word is assigned by the i_ws level during its bits before the final one. Level 0 means left and goes to o_left. Level 1 means right and goes to o_right.
- R5: When a word has more than DATA_W bits, only its first DATA_W bits are kept, and the rest do not alter the output.
- R6: When a word has fewer than DATA_W bits, its bits fill the most significant positions and the unused low-order bits are 0.
- R7: o_valid is a one-cycle pulse, issued once for each left word followed by a right word. It is issued after the right word completes, and o_left and o_right change only in the cycle where o_valid is 1.
- R8: The word that ends at the first i_ws transition after reset is discarded. A right word that completes without a full left word before it produces no o_valid.
- R9: Changes on i_sd while i_sck is high, after a rising edge, do not affect the captured data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_sck | input | 1 | Serial bit clock from the bus controller |
| i_ws | input | 1 | Word select, 0 = left, 1 = right |
| i_sd | input | 1 | Serial data, MSB first |
| o_left | output | DATA_W | Last complete left sample |
| o_right | output | DATA_W | Last complete right sample |
| o_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Exact-width words carrying distinctive end bits show whether the boundary bit is credited to the ending word (R3) or leaks into the next one. Words longer and shorter than DATA_W, including two-bit words, separate truncation from zero padding. Random lengths from 2 to 32 bits with random contents test both against a reference formula. Two start-up patterns, one opening mid-right and one opening mid-left, show whether the discard rule and the left-then-right pairing hold, and deliberate data toggles during the high phase of the bit clock show whether sampling happens only at rising edges.

// File: rtl/i2s_tgt_rx_pkg.sv
package i2s_tgt_rx_pkg;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   typedef struct packed {
      logic sck;
      logic ws;
      logic sd;
   } pins_t;

   localparam int PINS_W = $bits(pins_t);

endpackage

// File: rtl/i2s_tgt_rx_sync.sv
module i2s_tgt_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2s_tgt_rx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2s_tgt_rx_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/i2s_tgt_rx_front.sv
module i2s_tgt_rx_front
   import i2s_tgt_rx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sck_s,
   input  logic  ws_s,
   output logic  bit_stb,
   output logic  boundary,
   output chan_e end_chan
);

   logic sck_d;
   logic ws_last;
   logic have_ws;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         ws_last <= 1'b0;
         have_ws <= 1'b0;
      end else begin
         sck_d <= sck_s;
         if (bit_stb) begin
            ws_last <= ws_s;
            have_ws <= 1'b1;
         end
      end
   end

   assign bit_stb  = sck_s & ~sck_d;
   assign boundary = have_ws & (ws_s != ws_last);
   assign end_chan = chan_e'(ws_last);

endmodule

// File: rtl/i2s_tgt_rx_word.sv
module i2s_tgt_rx_word
   import i2s_tgt_rx_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_sd,
   input  logic              boundary,
   input  chan_e             end_chan,
   output logic              done,
   output chan_e             done_chan,
   output logic [DATA_W-1:0] done_data,
   output logic [CNT_W-1:0]  fill_cnt
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] word_ins;
   logic [CNT_W-1:0]  cnt_q;

   always_comb begin
      word_ins = word_q;
      for (int i = 0; i < DATA_W; i++) begin
         if (cnt_q == CNT_W'(DATA_W - 1 - i)) word_ins[i] = bit_sd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q    <= '0;
         cnt_q     <= '0;
         done      <= 1'b0;
         done_chan <= CH_LEFT;
         done_data <= '0;
      end else begin
         done <= 1'b0;
         if (bit_stb) begin
            if (boundary) begin
               done      <= 1'b1;
               done_chan <= end_chan;
               done_data <= word_ins;
               word_q    <= '0;
               cnt_q     <= '0;
            end else begin
               word_q <= word_ins;
               if (cnt_q != CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign fill_cnt = cnt_q;

endmodule

// File: rtl/i2s_tgt_rx.sv
module i2s_tgt_rx
   import i2s_tgt_rx_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_sck,
   input  logic              i_ws,
   input  logic              i_sd,
   output logic [DATA_W-1:0] o_left,
   output logic [DATA_W-1:0] o_right,
   output logic              o_valid
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("i2s_tgt_rx: DATA_W must be at least 2");
   end

   pins_t             pins_raw;
   pins_t             pins_s;
   logic              bit_stb;
   logic              boundary;
   chan_e             end_chan;
   logic              word_done;
   chan_e             word_chan;
   logic [DATA_W-1:0] word_data;
   logic [CNT_W-1:0]  word_cnt;

   logic              frame_armed;
   logic              left_ok;
   logic [DATA_W-1:0] left_hold;

   assign pins_raw = '{sck: i_sck, ws: i_ws, sd: i_sd};

   i2s_tgt_rx_sync #(
      .WIDTH  (PINS_W),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_raw),
      .q_sync  (pins_s)
   );

   i2s_tgt_rx_front i_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (pins_s.sck),
      .ws_s     (pins_s.ws),
      .bit_stb  (bit_stb),
      .boundary (boundary),
      .end_chan (end_chan)
   );

   i2s_tgt_rx_word #(
      .DATA_W (DATA_W)
   ) i_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .bit_sd    (pins_s.sd),
      .boundary  (boundary),
      .end_chan  (end_chan),
      .done      (word_done),
      .done_chan (word_chan),
      .done_data (word_data),
      .fill_cnt  (word_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_armed <= 1'b0;
         left_ok     <= 1'b0;
         left_hold   <= '0;
         o_left      <= '0;
         o_right     <= '0;
         o_valid     <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         if (word_done) begin
            if (!frame_armed) begin
               frame_armed <= 1'b1;
            end else if (word_chan == CH_LEFT) begin
               left_hold <= word_data;
               left_ok   <= 1'b1;
            end else if (left_ok) begin
               o_left  <= left_hold;
               o_right <= word_data;
               o_valid <= 1'b1;
               left_ok <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/i2s_tgt_rx_chk.sv
module i2s_tgt_rx_chk #(
   parameter int DATA_W = 16,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              o_valid,
   input logic [DATA_W-1:0] o_left,
   input logic [DATA_W-1:0] o_right,
   input logic              frame_armed,
   input logic              word_done,
   input logic [CNT_W-1:0]  word_cnt
);

   // R1: outputs clear as reset is released
   a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (!o_valid && o_left == '0 && o_right == '0));

   // R7: strobe lasts a single cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |=> !o_valid);

   // R7: outputs only move together with the strobe
   a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> ($stable(o_left) && $stable(o_right)));

   // R8: no pair before the first boundary has been consumed
   a_r8_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> frame_armed);

   // R5: bit counter saturates at the output width
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      word_cnt <= CNT_W'(DATA_W));

   // R3: word completion is a single-cycle event
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> !word_done);

endmodule

bind i2s_tgt_rx i2s_tgt_rx_chk #(.DATA_W(DATA_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .o_valid     (o_valid),
   .o_left      (o_left),
   .o_right     (o_right),
   .frame_armed (frame_armed),
   .word_done   (word_done),
   .word_cnt    (word_cnt)
);

// File: tb/test_i2s_tgt_rx.sv
`timescale 1ns/1ps
module test_i2s_tgt_rx;

   localparam int W    = 16;
   localparam int HALF = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         i_sck = 1'b0;
   logic         i_ws = 1'b0;
   logic         i_sd = 1'b0;
   logic [W-1:0] o_left;
   logic [W-1:0] o_right;
   logic         o_valid;

   int  checks = 0;
   int  errors = 0;
   int  vcount = 0;
   bit  glitch = 1'b0;
   bit  done_flag = 1'b0;

   always #4 clk = ~clk;

   i2s_tgt_rx #(.DATA_W(W)) i_i2s_tgt_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_sck   (i_sck),
      .i_ws    (i_ws),
      .i_sd    (i_sd),
      .o_left  (o_left),
      .o_right (o_right),
      .o_valid (o_valid)
   );

   always @(negedge clk) if (rst_n && o_valid) vcount++;

   function automatic logic [W-1:0] expect_word(logic [63:0] val, int len);
      logic [63:0] t;
      if (len >= W) t = val >> (len - W);
      else          t = val << (W - len);
      return t[W-1:0];
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(logic ws, logic sd);
      i_ws = ws;
      i_sd = sd;
      repeat (HALF) @(negedge clk);
      i_sck = 1'b1;
      repeat (2) @(negedge clk);
      if (glitch) i_sd = ~i_sd;
      repeat (HALF - 2) @(negedge clk);
      i_sck = 1'b0;
   endtask

   task automatic send_word(logic ch, logic [63:0] val, int len);
      for (int b = len - 1; b >= 0; b--)
         send_bit((b == 0) ? ~ch : ch, val[b]);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      i_sck = 1'b0;
      i_ws  = 1'b0;
      i_sd  = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic frame(string req, logic [63:0] lv, int ll, logic [63:0] rv, int rl);
      int c0;
      c0 = vcount;
      send_word(1'b0, lv, ll);
      send_word(1'b1, rv, rl);
      repeat (8) @(negedge clk);
      chk({req, "/R7 one strobe per frame"}, 64'(vcount - c0), 64'd1);
      chk({req, "/R4 left"}, 64'(o_left), 64'(expect_word(lv, ll)));
      chk({req, "/R4 right"}, 64'(o_right), 64'(expect_word(rv, rl)));
   endtask

   function automatic logic [63:0] rnd_val(int len);
      logic [63:0] v;
      v = {32'($urandom), 32'($urandom)};
      if (len < 64) v = v & ((64'd1 << len) - 64'd1);
      return v;
   endfunction

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h1250_5eed);
      do_reset();
      // R1: reset state
      chk("R1 valid", 64'(o_valid), 64'd0);
      chk("R1 left", 64'(o_left), 64'd0);
      chk("R1 right", 64'(o_right), 64'd0);

      // R8: start mid-right, partial word ended by first transition
      send_bit(1'b1, 1'b1);
      send_bit(1'b1, 1'b0);
      send_bit(1'b1, 1'b1);
      send_bit(1'b0, 1'b1);
      repeat (8) @(negedge clk);
      chk("R8 partial discarded", 64'(vcount), 64'd0);
      frame("R8", 64'h1234, 16, 64'hBEEF, 16);
      chk("R8 only one pair", 64'(vcount), 64'd1);

      // R2 exact width, R3 end bits
      frame("R2", 64'hA5C3, 16, 64'h7F01, 16);
      frame("R3", 64'h0001, 16, 64'h8001, 16);
      frame("R3", 64'h8000, 16, 64'hFFFE, 16);
      // R5 truncation
      frame("R5", 64'hABCDEF, 24, 64'h123456789, 36);
      // R6 zero padding
      frame("R6", 64'h5A, 8, 64'h3, 2);
      frame("R6", 64'h1, 2, 64'h7FF, 11);
      // R9 glitches on SD during high SCK phase
      glitch = 1'b1;
      frame("R9", 64'hC3A5, 16, 64'h0F0F, 16);
      frame("R9", 64'h1, 20, 64'hFFFFF, 20);
      glitch = 1'b0;

      // random lengths and contents
      for (int k = 0; k < 24; k++) begin
         int ll, rl;
         string tag;
         ll = 2 + int'($urandom % 31);
         rl = 2 + int'($urandom % 31);
         if (ll > W) tag = "R5";
         else if (ll < W) tag = "R6";
         else tag = "R2";
         glitch = bit'($urandom % 2);
         frame(tag, rnd_val(ll), ll, rnd_val(rl), rl);
      end
      glitch = 1'b0;

      // R8: start mid-left, then lone right word must not pair
      do_reset();
      chk("R1 valid after second reset", 64'(o_valid), 64'd0);
      begin
         int c0;
         c0 = vcount;
         send_bit(1'b0, 1'b1);
         send_bit(1'b0, 1'b1);
         send_bit(1'b1, 1'b0);
         send_word(1'b1, 64'h6666, 16);
         repeat (8) @(negedge clk);
         chk("R8 lone right no strobe", 64'(vcount - c0), 64'd0);
         chk("R8 left untouched", 64'(o_left), 64'd0);
         chk("R8 right untouched", 64'(o_right), 64'd0);
      end
      frame("R8", 64'h0BAD, 16, 64'hF00D, 16);

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule